// File: doc/BRIEF.md
# Iterative Forward NTT Engine

This block computes the forward number-theoretic transform of a 256-coefficient polynomial modulo q = 3329, with 12-bit coefficients. The logic is built for minimum area. A single Cooley-Tukey butterfly is reused for every stage. Coefficients stay in an internal register file with two read ports and two write ports. A read-only table holds the roots of unity, already scaled into Montgomery form. An address sequencer walks the seven stages, the groups inside each stage, and the pairs inside each group. It issues one butterfly per cycle.

A host loads the polynomial through a word-wide write port while the engine is not busy. It then pulses `start` and waits for `done`. The result is read back through the same port, with one cycle of read latency. The transformed coefficients remain in the register file in bit-reversed order.

The controller has five states:
- IDLE waits for `start` and goes to RUN.
- RUN issues butterflies. After the last pair of a stage it goes to DRAIN, or to FLUSH after stage 7.
- DRAIN lets the two-deep pipeline empty and then returns to RUN.
- FLUSH lets the pipeline empty and then goes to DONE.
- DONE holds `done` high and goes back to RUN on a new `start`.

Top module: `ntt_engine`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: Stage s (s = 1..7) pairs index j with j+len, where len = 128 >> (s−1). The groups are processed in ascending order. Each group uses one twiddle ζ_k = 17^brv7(k) mod 3329, with k counting 1..127 across the whole transform and brv7 the 7-bit bit reversal.
- R3: Each butterfly produces a' = (a + ω·b) mod q and b' = (a − ω·b) mod q, both in [0, q). The product ω·b is formed by Montgomery reduction with R = 2^16 and q⁻¹ mod 2^16 = 62209, using a twiddle stored as ω·2^16 mod q.
- R4: For any input with coefficients in [0, q), the stored result after `done` equals the in-place forward transform with the R2 ordering, read at address i for coefficient i.
- R5: Between stages, the sequencer inserts exactly two idle cycles. No read of a stage is issued before the last write-back of the previous stage.
- R6: `done` rises exactly 910 cycles after `start` is sampled in IDLE or DONE. This is 7·128 issue cycles plus 6·2 stall cycles plus 2 flush cycles. `done` then stays high until the next `start`.
- R7: While not busy, `host_we` writes `host_wdata` at `host_addr`. The word at `host_addr` appears on `host_rdata` one cycle after the address is presented.
- R8: While busy, `host_we` and `start` have no effect on the stored coefficients or on the sequence.
- R9: `busy` is high from the cycle after `start` is sampled until the last write-back, and is low once `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (ignored while busy) |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Transform finished, result held |
| host_we | input | 1 | Coefficient write enable |
| host_addr | input | 8 | Coefficient index |
| host_wdata | input | 12 | Coefficient to write |
| host_rdata | output | 12 | Coefficient read, one cycle after address |

## Verification
At every stage boundary, two operations meet: the write-back of the previous stage's final pair and the first read of the next stage. These are the two functions that can fall in the same cycle. Full transforms of impulses, constants, ramps and pseudo-random inputs provoke this collision six times per run. A wrong stall count corrupts the results against an arithmetic golden model, and it also shifts the measured 910-cycle latency. A second collision is provoked by driving host writes and a repeated `start` mid-run, while the butterfly write-back is using the shared write port. That run is judged by the final result still matching the golden model of the loaded data.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_FLUSH = 3'd3,
        ST_DONE  = 3'd4
    } ntt_state_e;

    function automatic int bit_rev(input int v, input int nbits);
        int r;
        r = 0;
        for (int i = 0; i < nbits; i++) r = (r << 1) | ((v >> i) & 1);
        return r;
    endfunction

    // root of unity for table slot k, scaled by 2^rbits mod q
    function automatic int twiddle_mont(input int k, input int hb, input int zeta,
                                        input int q, input int rbits);
        longint acc;
        int     e;
        acc = 1;
        e   = bit_rev(k, hb);
        for (int i = 0; i < e; i++) acc = (acc * longint'(zeta)) % longint'(q);
        acc = (acc << rbits) % longint'(q);
        return int'(acc);
    endfunction

endpackage

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom #(
    parameter int W     = 12,
    parameter int Q     = 3329,
    parameter int ZETA  = 17,
    parameter int HB    = 7,
    parameter int RBITS = 16
) (
    input  logic          clk,
    input  logic [HB-1:0] idx,
    output logic [W-1:0]  tw
);
    localparam int ENTRIES = 1 << HB;

    logic [W-1:0] table_w [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        localparam int VAL = ntt_pkg::twiddle_mont(i, HB, ZETA, Q, RBITS);
        assign table_w[i] = W'(VAL);
    end

    always_ff @(posedge clk) begin
        tw <= table_w[idx];
    end
endmodule

// File: rtl/ntt_coef_ram.sv
module ntt_coef_ram #(
    parameter int W  = 12,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [W-1:0]  wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [W-1:0]  wb_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        ra_data <= mem[ra_addr];
        rb_data <= mem[rb_addr];
        if (wa_en) mem[wa_addr] <= wa_data;
        if (wb_en) mem[wb_addr] <= wb_data;
    end
endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly #(
    parameter int W     = 12,
    parameter int Q     = 3329,
    parameter int QINV  = 62209,
    parameter int RBITS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] tw_in,
    output logic         out_valid,
    output logic [W-1:0] out_sum,
    output logic [W-1:0] out_diff
);
    localparam int PW = 2 * W;
    localparam int XW = RBITS + W + 2;
    localparam int UW = W + 2;
    localparam logic [RBITS-1:0] NEG_QINV = RBITS'((1 << RBITS) - QINV);
    localparam logic [UW-1:0]    QU       = UW'(Q);
    localparam logic [W:0]       QS       = (W + 1)'(Q);

    logic [PW-1:0]    prod;
    logic [RBITS-1:0] m;
    logic [XW-1:0]    u_sum;
    logic [UW-1:0]    u, t_red;
    logic [W-1:0]     t;
    logic [W:0]       s_full, s_red, d_red;

    // Montgomery product: tw = w*R mod q, so the reduction yields w*b mod q
    assign prod  = PW'(tw_in) * PW'(b_in);
    assign m     = prod[RBITS-1:0] * NEG_QINV;
    assign u_sum = XW'(prod) + XW'(m) * XW'(Q);
    assign u     = u_sum[XW-1:RBITS];
    assign t_red = (u >= QU) ? u - QU : u;
    assign t     = t_red[W-1:0];

    assign s_full = {1'b0, a_in} + {1'b0, t};
    assign s_red  = (s_full >= QS) ? s_full - QS : s_full;
    assign d_red  = (a_in >= t) ? {1'b0, a_in} - {1'b0, t}
                                : {1'b0, a_in} + QS - {1'b0, t};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_diff  <= '0;
        end else begin
            out_valid <= in_valid;
            out_sum   <= s_red[W-1:0];
            out_diff  <= d_red[W-1:0];
        end
    end

    // R3: the added multiple of q must clear the low half exactly
    p_mont_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (u_sum[RBITS-1:0] == '0));
    // R3: reduced product lies in [0, q)
    p_mont_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (t_red < QU));
    // R3: both butterfly results lie in [0, q)
    p_bf_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (s_red < QS) && (d_red < QS));
endmodule

// File: rtl/ntt_engine.sv
module ntt_engine
    import ntt_pkg::*;
#(
    parameter int LOGN  = 8,
    parameter int W     = 12,
    parameter int Q     = 3329,
    parameter int ZETA  = 17,
    parameter int QINV  = 62209,
    parameter int RBITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            done,
    input  logic            host_we,
    input  logic [LOGN-1:0] host_addr,
    input  logic [W-1:0]    host_wdata,
    output logic [W-1:0]    host_rdata
);
    localparam int HB = LOGN - 1;             // log2 of pairs per stage
    localparam int SW = $clog2(HB + 1);
    localparam logic [SW-1:0] LAST_STAGE = SW'(HB - 1);

    ntt_state_e state, state_nx;

    logic [SW-1:0]   stage;
    logic [HB-1:0]   pair, grp, tw_idx;
    logic [SW-1:0]   shamt;
    logic [LOGN-1:0] pair_x, len_x, offs_x, ja, jb;
    logic            issue, v1;
    logic [LOGN-1:0] a1_addr, b1_addr, a2_addr, b2_addr;
    logic [W-1:0]    ra_data, rb_data, tw, bf_sum, bf_diff;
    logic            v2;
    logic [LOGN-1:0] ra_addr, wa_addr;
    logic            wa_en;
    logic [W-1:0]    wa_data;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (start) state_nx = ST_RUN;
            ST_RUN:   if (&pair) state_nx = (stage == LAST_STAGE) ? ST_FLUSH : ST_DRAIN;
            ST_DRAIN: if (!v1) state_nx = ST_RUN;
            ST_FLUSH: if (!v1) state_nx = ST_DONE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy  = 1'b0;
        done  = 1'b0;
        issue = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_RUN:   begin busy = 1'b1; issue = 1'b1; end
            ST_DRAIN: busy = 1'b1;
            ST_FLUSH: busy = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // ---------------- address sequencer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '0;
            pair  <= '0;
        end else if (state == ST_RUN) begin
            pair <= pair + HB'(1);
            if (&pair) stage <= stage + SW'(1);
        end else if (state == ST_IDLE || state == ST_DONE) begin
            stage <= '0;
            pair  <= '0;
        end
    end

    assign shamt  = SW'(HB) - stage;
    assign pair_x = {1'b0, pair};
    assign len_x  = LOGN'(1) << shamt;
    assign grp    = pair >> shamt;
    assign offs_x = pair_x & (len_x - LOGN'(1));
    assign ja     = ({1'b0, grp} << ({1'b0, shamt} + (SW + 1)'(1))) | offs_x;
    assign jb     = ja + len_x;
    assign tw_idx = (HB'(1) << stage) + grp;

    // ---------------- pipeline ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1      <= 1'b0;
            a1_addr <= '0;
            b1_addr <= '0;
            a2_addr <= '0;
            b2_addr <= '0;
        end else begin
            v1      <= issue;
            a1_addr <= ja;
            b1_addr <= jb;
            a2_addr <= a1_addr;
            b2_addr <= b1_addr;
        end
    end

    assign ra_addr    = busy ? ja : host_addr;
    assign wa_en      = v2 | (host_we & ~busy);
    assign wa_addr    = v2 ? a2_addr : host_addr;
    assign wa_data    = v2 ? bf_sum : host_wdata;
    assign host_rdata = ra_data;

    ntt_coef_ram #(.W(W), .AW(LOGN)) u_ram (
        .clk     (clk),
        .ra_addr (ra_addr),
        .rb_addr (jb),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (v2),
        .wb_addr (b2_addr),
        .wb_data (bf_diff)
    );

    ntt_twiddle_rom #(.W(W), .Q(Q), .ZETA(ZETA), .HB(HB), .RBITS(RBITS)) u_rom (
        .clk (clk),
        .idx (tw_idx),
        .tw  (tw)
    );

    ntt_butterfly #(.W(W), .Q(Q), .QINV(QINV), .RBITS(RBITS)) u_bf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v1),
        .a_in      (ra_data),
        .b_in      (rb_data),
        .tw_in     (tw),
        .out_valid (v2),
        .out_sum   (bf_sum),
        .out_diff  (bf_diff)
    );

    // R2: the upper index of a pair always has the stage's span bit set, the lower clear
    p_pair_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> ((ja & len_x) == '0) && ((jb & len_x) != '0));
    // R5: the first read of a stage finds no write-back in flight
    p_stage_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_DRAIN) |-> (!v1 && !v2));
    // R6: done only once every write-back has landed
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!v1 && !v2));
    // R6: done holds until a new start
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R9: a sampled start raises busy on the next cycle
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_DONE) && start) |=> busy);
endmodule

// File: tb/test_ntt_engine.sv
`timescale 1ns/1ps
module test_ntt_engine;
    localparam int N  = 256;
    localparam int Q  = 3329;
    localparam int LAT = 7 * 128 + 6 * 2 + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [11:0] host_wdata = '0;
    logic        busy, done;
    logic [11:0] host_rdata;

    int total = 0;
    int bad   = 0;
    int stim [N];
    int gold [N];
    int zt   [128];
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    ntt_engine i_ntt_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int brv7(input int v);
        int r;
        r = 0;
        for (int i = 0; i < 7; i++) r = (r << 1) | ((v >> i) & 1);
        return r;
    endfunction

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % 32'd3329);
    endfunction

    task automatic build_golden();
        int k;
        k = 1;
        for (int i = 0; i < N; i++) gold[i] = stim[i];
        for (int len = 128; len >= 2; len = len >> 1) begin
            for (int st = 0; st < N; st += 2 * len) begin
                int z;
                z = zt[k];
                k++;
                for (int j = st; j < st + len; j++) begin
                    int t;
                    t = (z * gold[j + len]) % Q;
                    gold[j + len] = (gold[j] - t + Q) % Q;
                    gold[j]       = (gold[j] + t) % Q;
                end
            end
        end
    endtask

    task automatic load_stim();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            host_we    = 1'b1;
            host_addr  = 8'(i);
            host_wdata = 12'(stim[i]);
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic read_compare(input string req, input bit vs_stim);
        for (int i = 0; i < N; i++) begin
            int exp;
            @(negedge clk);
            host_addr = 8'(i);
            @(negedge clk);
            exp = vs_stim ? stim[i] : gold[i];
            check(int'(host_rdata) == exp, req, $sformatf("coef %0d", i),
                  int'(host_rdata), exp);
        end
    endtask

    task automatic run_ntt(input bit disturb);
        int cnt;
        int low_busy;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        low_busy = 0;
        check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        while (!done && cnt < 3000) begin
            if (disturb && (cnt == 100 || cnt == 500 || cnt == 909)) begin
                // R8: host write and a repeated start while busy
                host_we    = 1'b1;
                host_addr  = 8'(cnt % N);
                host_wdata = 12'd77;
                start      = 1'b1;
            end else begin
                host_we = 1'b0;
                start   = 1'b0;
            end
            @(negedge clk);
            cnt++;
            if (!done && !busy) low_busy++;
        end
        host_we = 1'b0;
        start   = 1'b0;
        check(cnt == LAT, "R5 R6", "start-to-done cycles", cnt, LAT);
        check(low_busy == 0, "R9", "cycles busy low before done", low_busy, 0);
        check(busy == 1'b0, "R9", "busy with done", int'(busy), 0);
    endtask

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // twiddle table: 17^brv7(k) mod q
        for (int k = 0; k < 128; k++) begin
            int acc;
            acc = 1;
            for (int e = 0; e < brv7(k); e++) acc = (acc * 17) % Q;
            zt[k] = acc;
        end

        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);

        // R7: plain load and read back
        for (int i = 0; i < N; i++) stim[i] = (i * 13 + 5) % Q;
        load_stim();
        read_compare("R7", 1'b1);

        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < N; i++) begin
                case (p)
                    0: stim[i] = 0;
                    1: stim[i] = (i == 0) ? 1 : 0;
                    2: stim[i] = Q - 1;
                    3: stim[i] = i;
                    4: stim[i] = next_rand();
                    5: stim[i] = (i == N - 1) ? Q - 1 : 0;
                    default: stim[i] = next_rand();
                endcase
            end
            build_golden();
            load_stim();
            run_ntt(p == 6);
            if (p == 6) read_compare("R8 R4", 1'b0);
            else        read_compare("R2 R3 R4", 1'b0);
            // R6: done still held after the whole readback
            check(done == 1'b1, "R6", "done held", int'(done), 1);
            if (p == 1) begin
                // R3: impulse at index 0 transforms to all ones
                @(negedge clk);
                host_addr = 8'd200;
                @(negedge clk);
                check(int'(host_rdata) == 1, "R3", "impulse coef 200", int'(host_rdata), 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule